// File: doc/BRIEF.md
# Vector Element Transpose Permute Unit

The unit takes two source vectors whose active length (`vl`) can change per operation, from 128 bits up to a parameter-set maximum in steps of 128. It cuts both sources into elements of a selectable width and pairs them up. For each pair it keeps either the even-indexed or the odd-indexed element of each source, and places them side by side in the destination. The first source supplies the low element of each destination pair and the second source supplies the high one. Any destination bits that no complete pair covers are cleared to zero.

A quadword mode fixes the element width at 128 bits. This mode depends on a feature-enable input. While the machine is in streaming mode, it also needs a separate full-instruction-set enable. The unit raises an illegal flag for an unusable length or for a quadword operation that is not allowed. The result is registered and returns one clock after the operation is presented, together with a valid strobe.

A two-state controller sequences the output. In `ST_IDLE` no result is presented. Taking `in_valid` moves it to `ST_EMIT` (transition *accept*). `ST_EMIT` holds for as long as `in_valid` keeps arriving (transition *stream*). When no new operation arrives, it returns to `ST_IDLE` (transition *drain*).

Top module: `vtp_top`

## Requirements
- R1: The element width is 8 << `size_code` when `quad_mode` = 0 (code 0 gives 8 bits, 1 gives 16, 2 gives 32, 3 gives 64). When `quad_mode` = 1 the width is 128 bits and `size_code` is ignored.
- R2: `odd_sel` = 0 picks the even-indexed elements (index 2p) of both sources. `odd_sel` = 1 picks the odd-indexed elements (index 2p+1).
- R3: The number of pairs is `vl` / (2 × width), rounded down. Destination element 2p is first-source element 2p+`odd_sel`. Destination element 2p+1 is second-source element 2p+`odd_sel`. Element e occupies bits [e×width +: width].
- R4: Every result bit at or above (pairs × 2 × width) is zero. This covers the top 128 bits of a quadword result when `vl` is an odd multiple of 128, and all bits above `vl`.
- R5: When `vl` < 2 × width, `illegal` is 1 and `result` is all zeros.
- R6: `illegal` is 1 and `result` is all zeros when `vl` is not a multiple of 128 or when `vl` exceeds `MAX_VL`.
- R7: A quadword operation is illegal, with a zero result, when `feat_quad_en` = 0, or when `streaming` = 1 and `stream_full_en` = 0. `streaming` has no effect on operations that are not quadword.
- R8: `out_valid` is 1 exactly in the cycle after a clock edge that samples `in_valid` = 1. `illegal` can be 1 only while `out_valid` is 1.
- R9: While reset is asserted and after it is released, with no operation presented yet, `out_valid`, `illegal` and `result` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operation presented this cycle |
| src_a | input | MAX_VL | First source vector |
| src_b | input | MAX_VL | Second source vector |
| size_code | input | 2 | Element width code |
| quad_mode | input | 1 | 128-bit element mode |
| odd_sel | input | 1 | 0 selects even elements, 1 selects odd elements |
| vl | input | $clog2(MAX_VL)+1 | Active vector length in bits |
| feat_quad_en | input | 1 | Quadword mode is implemented |
| streaming | input | 1 | Machine is in streaming mode |
| stream_full_en | input | 1 | Full instruction set allowed while streaming |
| out_valid | output | 1 | Result valid |
| result | output | MAX_VL | Destination vector |
| illegal | output | 1 | Operation is illegal |

## Verification
Every output (result, illegal flag and valid strobe) is due one rising edge after the edge that samples `in_valid`. Nothing about this block takes longer. The bench changes its inputs on the falling edge and reads the outputs on the next falling edge, so exactly one rising edge separates a stimulus from its check. Operations run back to back with no gap, so a stale result from an earlier operation would be caught. After the last operation the bench drops `in_valid` and checks that the valid strobe and the illegal flag fall on the next edge.

// File: rtl/vtp_pkg.sv
package vtp_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } vtp_state_e;

    localparam int VL_GRAN    = 128;
    localparam int NUM_WIDTHS = 5;   // 8,16,32,64 and quadword
    localparam int QUAD_IDX   = 4;
    localparam int QUAD_BITS  = 128;

    function automatic int elem_bits(input logic [1:0] code, input logic quad);
        return quad ? QUAD_BITS : (8 << code);
    endfunction

endpackage

// File: rtl/vtp_legal.sv
module vtp_legal
    import vtp_pkg::*;
#(
    parameter int MAX_VL = 2048,
    parameter int VLW    = $clog2(MAX_VL) + 1
) (
    input  logic [VLW-1:0] vl,
    input  logic [1:0]     size_code,
    input  logic           quad_mode,
    input  logic           feat_quad_en,
    input  logic           streaming,
    input  logic           stream_full_en,
    output logic           illegal
);
    logic [31:0] vl32;
    logic [31:0] pair_bits;
    logic        bad_gran;
    logic        too_long;
    logic        too_short;
    logic        quad_block;

    always_comb begin
        vl32       = 32'(vl);
        pair_bits  = 32'(2 * elem_bits(size_code, quad_mode));
        bad_gran   = (vl32 % VL_GRAN) != 0;
        too_long   = vl32 > 32'(MAX_VL);
        too_short  = vl32 < pair_bits;
        quad_block = quad_mode && (!feat_quad_en || (streaming && !stream_full_en));
        illegal    = bad_gran || too_long || too_short || quad_block;
    end
endmodule

// File: rtl/vtp_lane_perm.sv
module vtp_lane_perm #(
    parameter int MAX_VL = 2048,
    parameter int VLW    = $clog2(MAX_VL) + 1,
    parameter int ESZ    = 8
) (
    input  logic [MAX_VL-1:0] src_a,
    input  logic [MAX_VL-1:0] src_b,
    input  logic              odd_sel,
    input  logic [VLW-1:0]    vl,
    output logic [MAX_VL-1:0] perm
);
    localparam int NE = MAX_VL / ESZ;

    for (genvar e = 0; e < NE; e++) begin : g_elem
        localparam int PAIR  = e / 2;
        localparam int LO    = 2 * PAIR;
        localparam int LIMIT = (PAIR + 1) * 2 * ESZ;
        localparam logic [VLW-1:0] LIM_V = VLW'(LIMIT);

        logic [ESZ-1:0] picked;
        logic           in_pair;

        if (LO + 1 < NE) begin : g_full
            if (e % 2 == 0) begin : g_from_a
                assign picked = odd_sel ? src_a[(LO+1)*ESZ +: ESZ] : src_a[LO*ESZ +: ESZ];
            end else begin : g_from_b
                assign picked = odd_sel ? src_b[(LO+1)*ESZ +: ESZ] : src_b[LO*ESZ +: ESZ];
            end
            assign in_pair = (vl >= LIM_V);
        end else begin : g_orphan
            assign picked  = '0;
            assign in_pair = 1'b0;
        end

        assign perm[e*ESZ +: ESZ] = in_pair ? picked : '0;
    end
endmodule

// File: rtl/vtp_top.sv
module vtp_top
    import vtp_pkg::*;
#(
    parameter int MAX_VL = 2048,
    parameter int VLW    = $clog2(MAX_VL) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [MAX_VL-1:0] src_a,
    input  logic [MAX_VL-1:0] src_b,
    input  logic [1:0]        size_code,
    input  logic              quad_mode,
    input  logic              odd_sel,
    input  logic [VLW-1:0]    vl,
    input  logic              feat_quad_en,
    input  logic              streaming,
    input  logic              stream_full_en,
    output logic              out_valid,
    output logic [MAX_VL-1:0] result,
    output logic              illegal
);
    vtp_state_e state_q, state_d;

    logic [MAX_VL-1:0] lane_out [NUM_WIDTHS];
    logic [MAX_VL-1:0] perm_sel;
    logic              illegal_c;
    logic [2:0]        width_idx;

    for (genvar s = 0; s < NUM_WIDTHS; s++) begin : g_width
        vtp_lane_perm #(
            .MAX_VL (MAX_VL),
            .VLW    (VLW),
            .ESZ    (8 << s)
        ) u_lane (
            .src_a   (src_a),
            .src_b   (src_b),
            .odd_sel (odd_sel),
            .vl      (vl),
            .perm    (lane_out[s])
        );
    end

    vtp_legal #(
        .MAX_VL (MAX_VL),
        .VLW    (VLW)
    ) u_legal (
        .vl             (vl),
        .size_code      (size_code),
        .quad_mode      (quad_mode),
        .feat_quad_en   (feat_quad_en),
        .streaming      (streaming),
        .stream_full_en (stream_full_en),
        .illegal        (illegal_c)
    );

    always_comb begin
        width_idx = quad_mode ? 3'(QUAD_IDX) : {1'b0, size_code};
        perm_sel  = lane_out[width_idx];
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state: accept / stream / drain
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = in_valid ? ST_EMIT : ST_IDLE;
            ST_EMIT: state_d = in_valid ? ST_EMIT : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result  <= '0;
            illegal <= 1'b0;
        end else if (in_valid) begin
            result  <= illegal_c ? '0 : perm_sel;
            illegal <= illegal_c;
        end else begin
            illegal <= 1'b0;
        end
    end

    assign out_valid = (state_q == ST_EMIT);
endmodule

// File: rtl/vtp_checker.sv
module vtp_checker #(
    parameter int MAX_VL = 2048,
    parameter int VLW    = $clog2(MAX_VL) + 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [1:0]        size_code,
    input logic              quad_mode,
    input logic [VLW-1:0]    vl,
    input logic              feat_quad_en,
    input logic              streaming,
    input logic              stream_full_en,
    input logic              out_valid,
    input logic [MAX_VL-1:0] result,
    input logic              illegal
);
    logic [31:0] vl32;
    logic [31:0] need;
    assign vl32 = 32'(vl);
    assign need = quad_mode ? 32'd256 : (32'd16 << size_code);

    AST_SHORT_VL_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && vl32 < need |=> illegal && result == '0); // R5

    AST_VL_SHAPE_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && (vl32[6:0] != 7'd0 || vl32 > 32'(MAX_VL)) |=> illegal && result == '0); // R6

    AST_QUAD_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && quad_mode && (!feat_quad_en || (streaming && !stream_full_en)) |=> illegal); // R7

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R8

    AST_VALID_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid && !illegal); // R8

    AST_ILLEGAL_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> out_valid); // R8
endmodule

bind vtp_top vtp_checker #(
    .MAX_VL (MAX_VL),
    .VLW    (VLW)
) u_vtp_checker (
    .clk            (clk),
    .rst_n          (rst_n),
    .in_valid       (in_valid),
    .size_code      (size_code),
    .quad_mode      (quad_mode),
    .vl             (vl),
    .feat_quad_en   (feat_quad_en),
    .streaming      (streaming),
    .stream_full_en (stream_full_en),
    .out_valid      (out_valid),
    .result         (result),
    .illegal        (illegal)
);

// File: tb/vtp_top_bench.sv
`timescale 1ns/1ps
module vtp_top_bench;
    localparam int MAX_VL = 2048;
    localparam int VLW    = $clog2(MAX_VL) + 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic [MAX_VL-1:0] src_a = '0;
    logic [MAX_VL-1:0] src_b = '0;
    logic [1:0]        size_code = '0;
    logic              quad_mode = 1'b0;
    logic              odd_sel = 1'b0;
    logic [VLW-1:0]    vl = '0;
    logic              feat_quad_en = 1'b1;
    logic              streaming = 1'b0;
    logic              stream_full_en = 1'b0;
    logic              out_valid;
    logic [MAX_VL-1:0] result;
    logic              illegal;

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;
    bit finished = 0;

    always #4 clk = ~clk;   // 125 MHz

    vtp_top #(.MAX_VL(MAX_VL), .VLW(VLW)) u_vtp_top (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .src_a(src_a), .src_b(src_b), .size_code(size_code),
        .quad_mode(quad_mode), .odd_sel(odd_sel), .vl(vl),
        .feat_quad_en(feat_quad_en), .streaming(streaming),
        .stream_full_en(stream_full_en), .out_valid(out_valid),
        .result(result), .illegal(illegal)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000 && !finished) begin
            finished = 1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual %0d cycles expected under 100000", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    task automatic chk_bit(input string tag, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
        end
    endtask

    task automatic chk_vec(input string tag, input logic [MAX_VL-1:0] act,
                           input logic [MAX_VL-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // behavioural model built from R1..R7
    task automatic model(input logic [MAX_VL-1:0] a, input logic [MAX_VL-1:0] b,
                         input logic [1:0] sz, input logic q, input logic od,
                         input int vlen, input logic fq, input logic st, input logic fe,
                         output logic [MAX_VL-1:0] r, output logic ill);
        int esz = q ? 128 : (8 << sz);
        ill = (vlen % 128 != 0) || (vlen > MAX_VL) || (vlen < 2 * esz) ||
              (q && (!fq || (st && !fe)));
        r = '0;
        if (!ill) begin
            for (int p = 0; p < vlen / (2 * esz); p++) begin
                for (int k = 0; k < esz; k++) begin
                    r[(2*p)*esz + k]   = a[(2*p + od)*esz + k];
                    r[(2*p+1)*esz + k] = b[(2*p + od)*esz + k];
                end
            end
        end
    endtask

    function automatic logic [MAX_VL-1:0] rand_vec();
        logic [MAX_VL-1:0] v;
        for (int i = 0; i < MAX_VL/32; i++) v[i*32 +: 32] = $urandom;
        return v;
    endfunction

    // drive on falling edge, check one rising edge later at the next falling edge
    task automatic run_op(input string tag, input logic [MAX_VL-1:0] a,
                          input logic [MAX_VL-1:0] b, input logic [1:0] sz,
                          input logic q, input logic od, input int vlen,
                          input logic fq, input logic st, input logic fe);
        logic [MAX_VL-1:0] er;
        logic ei;
        model(a, b, sz, q, od, vlen, fq, st, fe, er, ei);
        src_a = a; src_b = b; size_code = sz; quad_mode = q; odd_sel = od;
        vl = VLW'(vlen); feat_quad_en = fq; streaming = st; stream_full_en = fe;
        in_valid = 1'b1;
        @(negedge clk);
        chk_bit({tag, " R8 valid"}, out_valid, 1'b1);
        chk_bit({tag, " illegal"}, illegal, ei);
        chk_vec({tag, " result"}, result, er);
    endtask

    logic [MAX_VL-1:0] ramp_a, ramp_b;

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < MAX_VL/8; i++) begin
            ramp_a[i*8 +: 8] = 8'(i);
            ramp_b[i*8 +: 8] = 8'(8'h80 | i);
        end

        // R9 reset state
        #3;
        chk_bit("R9 valid in reset", out_valid, 1'b0);
        chk_vec("R9 result in reset", result, '0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk_bit("R9 valid after reset", out_valid, 1'b0);
        chk_bit("R9 illegal after reset", illegal, 1'b0);

        // R1/R2/R3 directed with ramp patterns, every width, both parts
        for (int s = 0; s < 4; s++) begin
            run_op("R1 R3 even", ramp_a, ramp_b, 2'(s), 1'b0, 1'b0, 512, 1, 0, 0);
            run_op("R2 odd", ramp_a, ramp_b, 2'(s), 1'b0, 1'b1, 512, 1, 0, 0);
        end
        // R1 quad ignores size code
        run_op("R1 quad size3", ramp_a, ramp_b, 2'd3, 1'b1, 1'b1, 1024, 1, 0, 0);
        run_op("R1 quad size0", ramp_a, ramp_b, 2'd0, 1'b1, 1'b0, 1024, 1, 0, 0);
        // R4 tail zeroing
        run_op("R4 quad vl384", ramp_a, ramp_b, 2'd0, 1'b1, 1'b0, 384, 1, 0, 0);
        run_op("R4 quad vl1920", ramp_a, ramp_b, 2'd1, 1'b1, 1'b1, 1920, 1, 0, 0);
        run_op("R4 byte vl128", ramp_a, ramp_b, 2'd0, 1'b0, 1'b1, 128, 1, 0, 0);
        run_op("R3 full length", ramp_a, ramp_b, 2'd2, 1'b0, 1'b0, MAX_VL, 1, 0, 0);
        // R5 too short
        run_op("R5 quad vl128", ramp_a, ramp_b, 2'd0, 1'b1, 1'b0, 128, 1, 0, 0);
        run_op("R5 d64 vl128 legal edge", ramp_a, ramp_b, 2'd3, 1'b0, 1'b1, 128, 1, 0, 0);
        run_op("R5 vl0", ramp_a, ramp_b, 2'd0, 1'b0, 1'b0, 0, 1, 0, 0);
        // R6 bad shape
        run_op("R6 vl200", ramp_a, ramp_b, 2'd0, 1'b0, 1'b0, 200, 1, 0, 0);
        run_op("R6 vl2176", ramp_a, ramp_b, 2'd0, 1'b0, 1'b0, 2176, 1, 0, 0);
        // R7 quad gating
        run_op("R7 quad no feature", ramp_a, ramp_b, 2'd0, 1'b1, 1'b0, 512, 0, 0, 0);
        run_op("R7 quad streaming", ramp_a, ramp_b, 2'd0, 1'b1, 1'b0, 512, 1, 1, 0);
        run_op("R7 quad streaming full", ramp_a, ramp_b, 2'd0, 1'b1, 1'b1, 512, 1, 1, 1);
        run_op("R7 byte streaming", ramp_a, ramp_b, 2'd0, 1'b0, 1'b1, 512, 0, 1, 0);

        // constrained random, R3 against the model
        for (int n = 0; n < 300; n++) begin
            logic [1:0] sz = 2'($urandom_range(0, 3));
            logic q  = ($urandom_range(0, 4) == 0);
            logic od = 1'($urandom);
            int vlen = ($urandom_range(0, 9) == 0) ? int'($urandom_range(0, 2200))
                                                   : 128 * int'($urandom_range(1, 16));
            logic fq = ($urandom_range(0, 7) != 0);
            logic st = 1'($urandom);
            logic fe = 1'($urandom);
            run_op("R3 random", rand_vec(), rand_vec(), sz, q, od, vlen, fq, st, fe);
        end

        // R8 drain
        in_valid = 1'b0;
        @(negedge clk);
        chk_bit("R8 valid drops", out_valid, 1'b0);
        chk_bit("R8 illegal drops", illegal, 1'b0);

        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end
endmodule